// File: doc/BRIEF.md
# DDR Read-Data Latency Serializer

This block models the read data path of a double-data-rate memory device. It runs on a tick at twice the memory clock rate, so one tick is half a memory clock. The block tracks which ticks stand for rising clock edges and which stand for falling ones. When a read is issued on a rising-edge tick, the block captures a 2n-bit core word and delays it by a selectable read latency, counted in half clocks. It then sends the word as two n-bit beats on consecutive ticks.

Alongside the beats it drives a strobe enable and a strobe level. One tick of strobe preamble comes before the first beat, and the strobe toggles with every beat. It falls idle after the last beat. A latency with a half-clock fraction moves the first beat onto a falling clock edge. Reads issued on consecutive clocks stream out with no gap.

Top module: `ddr_rd_serializer`

## Requirements
- R1: While reset is asserted and until the first read, `beat_vld`, `dqs_oe`, `dqs_lvl`, `beat_dat` and `ck_hi` are all 0.
- R2: After reset, `ck_hi` toggles on every tick. A tick edge that `ck_hi`=0 precedes is a rising clock edge. `rd_issue` is sampled only at those edges, and a `rd_issue` seen at a falling-edge tick has no effect on any output.
- R3: `lat_sel` codes 0, 1, 2 and 3 select read latencies of 1.5, 2, 2.5 and 3 clocks, which is L = 3, 4, 5 and 6 ticks. For a read accepted at tick edge t, the first beat is valid after edge t+L.
- R4: The first beat carries `core_word[BEAT_W-1:0]`. The second beat carries `core_word[2*BEAT_W-1:BEAT_W]` and follows after edge t+L+1.
- R5: With codes 1 and 3 the first beat leaves on a rising clock edge (`ck_hi`=1 after it). With codes 0 and 2 it leaves on a falling clock edge (`ck_hi`=0 after it).
- R6: When the tick before the first beat carries no beat, that tick is a preamble: `dqs_oe`=1, `dqs_lvl`=0 and `beat_vld`=0. A preamble tick is always followed by a first beat.
- R7: `dqs_lvl` is 1 with every first beat and 0 with every second beat. A first beat is always followed by its second beat. `dqs_lvl` and `beat_vld` are never 1 while `dqs_oe` is 0.
- R8: On the tick after the last beat of a stream, `dqs_oe` and `beat_vld` return to 0.
- R9: Reads accepted on consecutive rising edges give a gap-free run of beats with `dqs_oe` held high. There is no preamble between the reads.
- R10: The latency code and the core word are captured at acceptance. Later changes on `lat_sel` or `core_word` do not alter reads already in flight.
- R11: `beat_dat` is 0 on every tick where `beat_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, twice the memory clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_issue | input | 1 | Read request; takes effect only on rising-edge ticks |
| lat_sel | input | SEL_W | Read latency code (0: 1.5, 1: 2, 2: 2.5, 3: 3 clocks) |
| core_word | input | 2*BEAT_W | Word fetched from the core for this read |
| ck_hi | output | 1 | High during the first half of the memory clock |
| beat_dat | output | BEAT_W | Current output beat |
| beat_vld | output | 1 | Beat on `beat_dat` is valid |
| dqs_oe | output | 1 | Strobe driven (preamble or beat) |
| dqs_lvl | output | 1 | Strobe level while driven |

## Verification
A read accepted at tick edge t shows its preamble after edge t+L-1. Its two beats follow after edges t+L and t+L+1, and the strobe goes idle after edge t+L+2, where L is 3 to 6 ticks. A stream of three reads adds two ticks of beats per extra read. The stimulus and the sampling run in parallel. The sampling side counts falling bench edges from the acceptance edge and compares every output against the value due at that exact tick, including the `ck_hi` phase. Every latency code is tried both singly and as a stream. A falling-edge request is also issued, and the strobe is watched to confirm it stays idle.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

  localparam int TICK_W = 4;

  typedef logic [TICK_W-1:0] tick_t;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_PRE    = 2'd1,
    BK_FIRST  = 2'd2,
    BK_SECOND = 2'd3
  } beat_kind_e;

  // Half-clock ticks between acceptance and the first beat.
  function automatic tick_t code_to_ticks(input int unsigned code);
    return tick_t'(code + 3);
  endfunction

endpackage

// File: rtl/ddr_rd_rst_sync.sv
module ddr_rd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_int_n = sync_q[STAGES-1];

endmodule

// File: rtl/ddr_rd_phase.sv
module ddr_rd_phase (
  input  logic clk,
  input  logic rst_int_n,
  input  logic rd_issue,
  output logic ck_hi,
  output logic accept
);

  logic ph_q;
  logic ph_d;

  always_comb begin
    ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ph_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
    end
  end

  // ph_q low before an edge marks that edge as a rising clock edge.
  assign accept = rd_issue & ~ph_q;
  assign ck_hi  = ph_q;

endmodule

// File: rtl/ddr_rd_pipe.sv
module ddr_rd_pipe
  import ddr_rd_pkg::*;
#(
  parameter int BEAT_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_int_n,
  input  logic                  accept,
  input  logic [SEL_W-1:0]      lat_sel,
  input  logic [2*BEAT_W-1:0]   core_word,
  output beat_kind_e            kind,
  output logic [BEAT_W-1:0]     beat_word
);

  localparam int MAX_TICKS = (1 << SEL_W) + 2;
  localparam int DEPTH     = MAX_TICKS + 1;
  localparam int WORD_W    = 2 * BEAT_W;

  logic [DEPTH-1:0]  v_q;
  logic [DEPTH-1:0]  v_d;
  tick_t             lat_q [DEPTH];
  tick_t             lat_d [DEPTH];
  logic [WORD_W-1:0] w_q   [DEPTH];
  logic [WORD_W-1:0] w_d   [DEPTH];
  logic              shift_en;

  logic [DEPTH-1:0]  first_hit;
  logic [DEPTH-1:0]  second_hit;
  logic [DEPTH-1:0]  pre_hit;

  // Slot 0 takes a new read; each tick every slot moves one step on.
  always_comb begin
    shift_en = accept | (|v_q);
    v_d[0]   = accept;
    lat_d[0] = accept ? code_to_ticks(int'(lat_sel)) : '0;
    w_d[0]   = accept ? core_word : '0;
    for (int j = 1; j < DEPTH; j++) begin
      v_d[j]   = v_q[j-1];
      lat_d[j] = lat_q[j-1];
      w_d[j]   = w_q[j-1];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      v_q <= '0;
      for (int j = 0; j < DEPTH; j++) begin
        lat_q[j] <= '0;
        w_q[j]   <= '0;
      end
    end else if (shift_en) begin
      v_q <= v_d;
      for (int j = 0; j < DEPTH; j++) begin
        lat_q[j] <= lat_d[j];
        w_q[j]   <= w_d[j];
      end
    end
  end

  // Per-slot due tests: a slot at index j has aged j+1 ticks at the next edge.
  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    assign first_hit[j]  = v_q[j] && (lat_q[j] == tick_t'(j + 1));
    assign second_hit[j] = v_q[j] && (lat_q[j] == tick_t'(j));
    assign pre_hit[j]    = v_q[j] && (lat_q[j] == tick_t'(j + 2));
  end

  logic [BEAT_W-1:0] lo_mux;
  logic [BEAT_W-1:0] hi_mux;

  always_comb begin
    lo_mux = '0;
    hi_mux = '0;
    for (int j = 0; j < DEPTH; j++) begin
      lo_mux = lo_mux | ({BEAT_W{first_hit[j]}}  & w_q[j][BEAT_W-1:0]);
      hi_mux = hi_mux | ({BEAT_W{second_hit[j]}} & w_q[j][WORD_W-1:BEAT_W]);
    end
    if (|first_hit) begin
      kind      = BK_FIRST;
      beat_word = lo_mux;
    end else if (|second_hit) begin
      kind      = BK_SECOND;
      beat_word = hi_mux;
    end else if (|pre_hit) begin
      kind      = BK_PRE;
      beat_word = '0;
    end else begin
      kind      = BK_IDLE;
      beat_word = '0;
    end
  end

endmodule

// File: rtl/ddr_rd_out.sv
module ddr_rd_out
  import ddr_rd_pkg::*;
#(
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_int_n,
  input  beat_kind_e        kind,
  input  logic [BEAT_W-1:0] beat_word,
  output logic [BEAT_W-1:0] beat_dat,
  output logic              beat_vld,
  output logic              dqs_oe,
  output logic              dqs_lvl
);

  logic [BEAT_W-1:0] dat_q, dat_d;
  logic              vld_q, vld_d;
  logic              oe_q, oe_d;
  logic              lvl_q, lvl_d;
  logic              upd_en;

  always_comb begin
    dat_d = '0;
    vld_d = 1'b0;
    oe_d  = 1'b0;
    lvl_d = 1'b0;
    unique case (kind)
      BK_FIRST: begin
        dat_d = beat_word;
        vld_d = 1'b1;
        oe_d  = 1'b1;
        lvl_d = 1'b1;
      end
      BK_SECOND: begin
        dat_d = beat_word;
        vld_d = 1'b1;
        oe_d  = 1'b1;
      end
      BK_PRE: begin
        oe_d = 1'b1;
      end
      default: begin
      end
    endcase
    upd_en = oe_d | oe_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dat_q <= '0;
      vld_q <= 1'b0;
      oe_q  <= 1'b0;
      lvl_q <= 1'b0;
    end else if (upd_en) begin
      dat_q <= dat_d;
      vld_q <= vld_d;
      oe_q  <= oe_d;
      lvl_q <= lvl_d;
    end
  end

  assign beat_dat = dat_q;
  assign beat_vld = vld_q;
  assign dqs_oe   = oe_q;
  assign dqs_lvl  = lvl_q;

endmodule

// File: rtl/ddr_rd_serializer.sv
module ddr_rd_serializer
  import ddr_rd_pkg::*;
#(
  parameter int BEAT_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_issue,
  input  logic [SEL_W-1:0]    lat_sel,
  input  logic [2*BEAT_W-1:0] core_word,
  output logic                ck_hi,
  output logic [BEAT_W-1:0]   beat_dat,
  output logic                beat_vld,
  output logic                dqs_oe,
  output logic                dqs_lvl
);

  logic              rst_int_n;
  logic              accept;
  beat_kind_e        kind;
  logic [BEAT_W-1:0] beat_word;

  ddr_rd_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  ddr_rd_phase u_phase (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .rd_issue  (rd_issue),
    .ck_hi     (ck_hi),
    .accept    (accept)
  );

  ddr_rd_pipe #(.BEAT_W(BEAT_W), .SEL_W(SEL_W)) u_pipe (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .accept    (accept),
    .lat_sel   (lat_sel),
    .core_word (core_word),
    .kind      (kind),
    .beat_word (beat_word)
  );

  ddr_rd_out #(.BEAT_W(BEAT_W)) u_out (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .kind      (kind),
    .beat_word (beat_word),
    .beat_dat  (beat_dat),
    .beat_vld  (beat_vld),
    .dqs_oe    (dqs_oe),
    .dqs_lvl   (dqs_lvl)
  );

endmodule

// File: rtl/ddr_rd_serializer_chk.sv
module ddr_rd_serializer_chk #(
  parameter int BEAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ck_hi,
  input logic [BEAT_W-1:0] beat_dat,
  input logic              beat_vld,
  input logic              dqs_oe,
  input logic              dqs_lvl
);

  logic [2:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != 3'd7) begin
      age_q <= age_q + 3'd1;
    end
  end

  // R2: phase alternates once the internal reset has released
  p_phase_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd4) |-> (ck_hi != $past(ck_hi)));

  // R7: beat valid only while the strobe is driven
  p_vld_in_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld |-> dqs_oe);

  // R7: strobe level high only while driven
  p_lvl_in_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_lvl |-> dqs_oe);

  // R7: a first beat is followed by its second beat
  p_first_then_second_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && dqs_lvl) |=> (beat_vld && !dqs_lvl));

  // R6: a preamble tick is followed by a first beat
  p_pre_then_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dqs_oe && !beat_vld) |=> (beat_vld && dqs_lvl));

  // R11: data bus rests at zero without a beat
  p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_vld |-> (beat_dat == '0));

endmodule

bind ddr_rd_serializer ddr_rd_serializer_chk #(.BEAT_W(BEAT_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ck_hi    (ck_hi),
  .beat_dat (beat_dat),
  .beat_vld (beat_vld),
  .dqs_oe   (dqs_oe),
  .dqs_lvl  (dqs_lvl)
);

// File: tb/test_ddr_rd_serializer.sv
module test_ddr_rd_serializer;

  localparam int BW = 8;

  logic          clk;
  logic          rst_n;
  logic          rd_issue;
  logic [1:0]    lat_sel;
  logic [2*BW-1:0] core_word;
  logic          ck_hi;
  logic [BW-1:0] beat_dat;
  logic          beat_vld;
  logic          dqs_oe;
  logic          dqs_lvl;

  int n_chk;
  int n_err;

  ddr_rd_serializer #(.BEAT_W(BW), .SEL_W(2)) i_ddr_rd_serializer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_issue  (rd_issue),
    .lat_sel   (lat_sel),
    .core_word (core_word),
    .ck_hi     (ck_hi),
    .beat_dat  (beat_dat),
    .beat_vld  (beat_vld),
    .dqs_oe    (dqs_oe),
    .dqs_lvl   (dqs_lvl)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_gap(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Reads issued on consecutive rising edges; n = 1 is a single read.
  task automatic run_reads(input logic [1:0] code, input int n,
                           input logic [15:0] a, input logic [15:0] b,
                           input logic [15:0] c);
    logic [15:0] w [3];
    int L;
    w[0] = a; w[1] = b; w[2] = c;
    L = int'(code) + 3;
    do @(negedge clk); while (ck_hi !== 1'b0);
    fork
      begin
        lat_sel = code;
        for (int i = 0; i < n; i++) begin
          core_word = w[i];
          rd_issue  = 1'b1;
          @(negedge clk);
          @(negedge clk);
        end
        rd_issue  = 1'b0;
        lat_sel   = code + 2'd1;   // R10: change after acceptance
        core_word = 16'hDEAD;
      end
      begin
        for (int k = 0; k <= L + 2*n; k++) begin
          @(negedge clk);
          chk(ck_hi == 1'((k + 1) % 2), "R2 phase", 32'(ck_hi), 32'((k + 1) % 2));
          if (k >= L && k < L + 2*n) begin
            int idx;
            logic [BW-1:0] ed;
            idx = k - L;
            ed  = (idx % 2 == 1) ? w[idx/2][15:8] : w[idx/2][7:0];
            chk(beat_vld === 1'b1, "R3 beat valid", 32'(beat_vld), 1);
            chk(beat_dat === ed, "R4 R10 beat data", 32'(beat_dat), 32'(ed));
            chk(dqs_lvl === (idx % 2 == 0), "R7 strobe level", 32'(dqs_lvl),
                32'(idx % 2 == 0));
            chk(dqs_oe === 1'b1, "R9 strobe held", 32'(dqs_oe), 1);
            if (idx == 0)
              chk(ck_hi == 1'(code[0]), "R5 first beat edge", 32'(ck_hi),
                  32'(code[0]));
          end else if (k == L - 1) begin
            chk(dqs_oe === 1'b1 && dqs_lvl === 1'b0 && beat_vld === 1'b0,
                "R6 preamble", {29'd0, dqs_oe, dqs_lvl, beat_vld}, 32'b100);
          end else begin
            chk(dqs_oe === 1'b0 && beat_vld === 1'b0,
                (k == L + 2*n) ? "R8 postamble idle" : "R3 early quiet",
                {30'd0, dqs_oe, beat_vld}, 0);
            chk(beat_dat === '0, "R11 bus zero", 32'(beat_dat), 0);
          end
        end
      end
    join
    idle_gap(6);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; rd_issue = 1'b0; lat_sel = 2'd0; core_word = '0;
    idle_gap(3);
    chk(beat_vld === 1'b0 && dqs_oe === 1'b0 && dqs_lvl === 1'b0,
        "R1 reset outputs", {29'd0, beat_vld, dqs_oe, dqs_lvl}, 0);
    chk(beat_dat === '0, "R1 reset data", 32'(beat_dat), 0);
    chk(ck_hi === 1'b0, "R1 reset phase", 32'(ck_hi), 0);
    rst_n = 1'b1;
    idle_gap(6);
    chk(dqs_oe === 1'b0 && beat_vld === 1'b0, "R1 idle after reset",
        {30'd0, dqs_oe, beat_vld}, 0);
  endtask

  task automatic test_fall_ignored();
    do @(negedge clk); while (ck_hi !== 1'b1);
    core_word = 16'hA55A;
    lat_sel   = 2'd1;
    rd_issue  = 1'b1;
    @(negedge clk);
    rd_issue  = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(dqs_oe === 1'b0 && beat_vld === 1'b0, "R2 falling request ignored",
          {30'd0, dqs_oe, beat_vld}, 0);
    end
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    test_reset();
    for (int c = 0; c < 4; c++)
      run_reads(2'(c), 1, 16'h1234 + 16'(c), 16'h0, 16'h0);
    for (int c = 0; c < 4; c++)
      run_reads(2'(c), 3, 16'hC3A1 ^ 16'(c), 16'h5E7F, 16'h0FF0 + 16'(c));
    test_fall_ignored();
    run_reads(2'd2, 2, 16'hFF00, 16'h00FF, 16'h0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule